// File: doc/BRIEF.md
# Paged Memory Decoder with Shared External Bus Arbiter

This block sits between a processor core's memory ports and the chip pins. It takes word addresses from a program-memory port, a data-memory port and an I/O port. For each access it decides which target serves it: one of three on-chip RAM blocks, the boot ROM, on-chip I/O, or the external bus. Memory addresses are 24 bits wide. The upper 8 bits give the page, so there are 256 pages, and the lower 16 bits give the word offset within the page. I/O addresses are 18 bits wide and are divided into pages of 1K words.

Accesses to on-chip targets are acknowledged one cycle after the request. Accesses to external space compete for the single external address and data bus. The arbiter grants the bus to one port at a time. It drives the address, the write data and exactly one select strobe, either one of four memory-bank selects or the external I/O select. It holds that strobe for a wait-state count that is programmed per bank. A bank in acknowledge mode can stretch the transfer further. A small write-only configuration port sets three page boundaries that split external memory into banks, and the wait count and mode of each bank and of external I/O.

A requester holds `req` and its address steady until it sees `rdy`. It then drops or changes the request on the following cycle.

Top module: `xbus_paged_ctrl`

## Requirements
- R1: Page 0 decodes by offset. Offsets 0x0000–0x3FFF return target code 1 (RAM block 0). Offsets 0x4000–0x7FFF return code 2 (RAM block 1). Offsets 0x8000–0x9FFF return code 3 (RAM block 2). Any other page-0 offset returns code 6 (error). Each of these raises `rdy` one cycle after the request is presented, and `tgt` carries the code while `rdy` is high.
- R2: In page 0xFF, offsets 0xF000–0xFFFF return code 4 (boot ROM), with the same one-cycle `rdy`. Any other offset in page 0xFF is external.
- R3: Every other memory address is external and reports code 5. The bank is chosen by the page number P and the three boundary registers: P < B0 selects bank 0, else P < B1 selects bank 1, else P < B2 selects bank 2, else bank 3. Bank k drives `x_ms[k]`.
- R4: On the I/O port, I/O page `io_addr[17:10]` below 32 is on-chip and returns code 7 after one cycle. Any higher page is external, returns code 5 and drives `x_ioms`.
- R5: During an external transfer, `xa` carries the low 20 bits of the memory address, or the zero-extended I/O address. `xd_out` carries the write data, and both `x_we` and `xd_oe` equal the write flag.
- R6: A granted transfer holds its select for W+1 cycles, where W is the wait count of its bank. `rdy` for the owner rises for exactly one cycle after the select drops.
- R7: In acknowledge mode (mode bit 1), once the wait count is exhausted the transfer continues while `x_ack` is low. It ends on the first cycle in which `x_ack` is high.
- R8: When several ports want the external bus in the same cycle, the data-memory port wins, then the program-memory port, then the I/O port. Losing ports wait and are served in that order.
- R9: At most one of `x_ms[3:0]`, `x_ioms` is high at any time. None is high while no transfer is in progress.
- R10: A configuration write at `cfg_addr` 0, 1 or 2 loads boundary B0, B1 or B2 from `cfg_wdata[7:0]`. Address 3 loads the external I/O wait setting. Address 4+k loads bank k. A wait setting takes its count from `cfg_wdata[3:0]` and its mode from `cfg_wdata[15]`. The count and mode are latched when a transfer is granted, so a write during a transfer does not change that transfer.
- R11: After reset no select, `rdy`, `x_we` or `xd_oe` is active. All ready data is zero. The boundaries are 0x40, 0x80 and 0xC0, and every wait count and mode is zero.
- R12: When an external read completes, `rdata` carries the value of `xd_in` sampled in the last strobe cycle, in the same cycle as `rdy`. In all other cycles `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| dm_req | input | 1 | Data-memory port request |
| dm_addr | input | 24 | Data-memory word address |
| dm_we | input | 1 | Data-memory write flag |
| dm_wdata | input | 16 | Data-memory write data |
| dm_rdy | output | 1 | Data-memory access complete |
| dm_tgt | output | 3 | Target code of the completed data-memory access |
| dm_rdata | output | 16 | External read data for the data-memory port |
| pm_req | input | 1 | Program-memory port request |
| pm_addr | input | 24 | Program-memory word address |
| pm_we | input | 1 | Program-memory write flag |
| pm_wdata | input | 16 | Program-memory write data |
| pm_rdy | output | 1 | Program-memory access complete |
| pm_tgt | output | 3 | Target code of the completed program-memory access |
| pm_rdata | output | 16 | External read data for the program-memory port |
| io_req | input | 1 | I/O port request |
| io_addr | input | 18 | I/O word address |
| io_we | input | 1 | I/O write flag |
| io_wdata | input | 16 | I/O write data |
| io_rdy | output | 1 | I/O access complete |
| io_tgt | output | 3 | Target code of the completed I/O access |
| io_rdata | output | 16 | External read data for the I/O port |
| xa | output | 20 | External address bus |
| xd_out | output | 16 | External write data |
| xd_oe | output | 1 | External data output enable |
| xd_in | input | 16 | External read data |
| x_we | output | 1 | External write strobe |
| x_ack | input | 1 | External acknowledge for acknowledge-mode banks |
| x_ms | output | 4 | External memory bank selects |
| x_ioms | output | 1 | External I/O select |

## Verification
On-chip targets answer on the first clock edge after the request. An external transfer shows its select, address and data right after the granting edge. It holds them for W+1 cycles plus any acknowledge stretch, and `rdy` and `rdata` appear one edge after the last strobe cycle. The bench drives inputs at the falling edge and advances its model at each rising edge, using the same pre-edge inputs the design sees. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks then count strobe cycles and ready order against the values that R6–R8 and R10 give.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int NB     = 4;   // external memory banks
  localparam int BANK_W = 2;
  localparam int NPORT  = 3;   // dm, pm, io
  localparam int PORT_W = 2;

  localparam logic [PORT_W-1:0] PORT_DM = 2'd0;
  localparam logic [PORT_W-1:0] PORT_PM = 2'd1;
  localparam logic [PORT_W-1:0] PORT_IO = 2'd2;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_RAM0  = 3'd1,
    TGT_RAM1  = 3'd2,
    TGT_RAM2  = 3'd3,
    TGT_ROM   = 3'd4,
    TGT_EXT   = 3'd5,
    TGT_BAD   = 3'd6,
    TGT_IOINT = 3'd7
  } tgt_e;
endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
  import xbus_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int WAIT_W = 4,
  parameter int DW     = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_addr,
  input  logic [DW-1:0]                cfg_wdata,
  output logic [NB-2:0][PAGE_W-1:0]    bnd,
  output logic [NB:0][WAIT_W-1:0]      wcount,
  output logic [NB:0]                  wmode
);
  // index NB of wcount/wmode is the external I/O setting
  localparam logic [2:0] IO_SLOT = 3'd3;
  localparam logic [2:0] BANK0_SLOT = 3'd4;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NB-1; k++)
        bnd[k] <= PAGE_W'((k + 1) * ((2 ** PAGE_W) / NB));
      wcount <= '0;
      wmode  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < IO_SLOT) begin
        bnd[cfg_addr[1:0]] <= cfg_wdata[PAGE_W-1:0];
      end else if (cfg_addr == IO_SLOT) begin
        wcount[NB] <= cfg_wdata[WAIT_W-1:0];
        wmode[NB]  <= cfg_wdata[DW-1];
      end else begin
        wcount[cfg_addr - BANK0_SLOT] <= cfg_wdata[WAIT_W-1:0];
        wmode[cfg_addr - BANK0_SLOT]  <= cfg_wdata[DW-1];
      end
    end
  end

  // R10: boundaries stay ascending only if software writes them so; check that
  // reset leaves them ascending.
  a_r11_reset_bounds: assert property (@(posedge clk)
    $fell(rst) |-> (bnd[0] < bnd[1]) && (bnd[1] < bnd[2]) && (wcount == '0));
endmodule

// File: rtl/xbus_mem_decode.sv
module xbus_mem_decode
  import xbus_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_W     = 8,
  parameter int RAM0_WORDS = 16384,
  parameter int RAM1_WORDS = 16384,
  parameter int RAM2_WORDS = 8192,
  parameter int ROM_WORDS  = 4096
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NB-2:0][PAGE_W-1:0]  bnd,
  output tgt_e                       tgt,
  output logic [BANK_W-1:0]          bank
);
  localparam int OFF_W = ADDR_W - PAGE_W;
  localparam logic [OFF_W:0] END0 = (OFF_W+1)'(RAM0_WORDS);
  localparam logic [OFF_W:0] END1 = (OFF_W+1)'(RAM0_WORDS + RAM1_WORDS);
  localparam logic [OFF_W:0] END2 = (OFF_W+1)'(RAM0_WORDS + RAM1_WORDS + RAM2_WORDS);
  localparam logic [OFF_W:0] ROM_BASE = (OFF_W+1)'((2 ** OFF_W) - ROM_WORDS);

  logic [PAGE_W-1:0] page;
  logic [OFF_W:0]    off;

  assign page = addr[ADDR_W-1:OFF_W];
  assign off  = {1'b0, addr[OFF_W-1:0]};

  always_comb begin
    bank = BANK_W'(NB - 1);
    for (int k = NB - 2; k >= 0; k--)
      if (page < bnd[k]) bank = BANK_W'(k);
  end

  always_comb begin
    if (page == '0) begin
      if (off < END0)      tgt = TGT_RAM0;
      else if (off < END1) tgt = TGT_RAM1;
      else if (off < END2) tgt = TGT_RAM2;
      else                 tgt = TGT_BAD;
    end else if ((&page) && (off >= ROM_BASE)) begin
      tgt = TGT_ROM;
    end else begin
      tgt = TGT_EXT;
    end
  end
endmodule

// File: rtl/xbus_io_decode.sv
module xbus_io_decode
  import xbus_pkg::*;
#(
  parameter int IO_W          = 18,
  parameter int IO_PAGE_SHIFT = 10,
  parameter int IO_INT_PAGES  = 32
) (
  input  logic [IO_W-1:0] io_addr,
  output tgt_e            tgt
);
  localparam int IOP_W = IO_W - IO_PAGE_SHIFT;
  localparam logic [IOP_W-1:0] INT_LIM = IOP_W'(IO_INT_PAGES);

  logic [IOP_W-1:0] io_page;
  assign io_page = io_addr[IO_W-1:IO_PAGE_SHIFT];
  assign tgt = (io_page < INT_LIM) ? TGT_IOINT : TGT_EXT;
endmodule

// File: rtl/xbus_ext_arb.sv
module xbus_ext_arb
  import xbus_pkg::*;
#(
  parameter int XA_W   = 20,
  parameter int XD_W   = 16,
  parameter int WAIT_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NPORT-1:0]               want,
  input  logic [NPORT-1:0][XA_W-1:0]     p_xa,
  input  logic [NPORT-1:0]               p_we,
  input  logic [NPORT-1:0][XD_W-1:0]     p_wdata,
  input  logic [NPORT-1:0][BANK_W-1:0]   p_bank,
  input  logic [NB:0][WAIT_W-1:0]        wcount,
  input  logic [NB:0]                    wmode,
  input  logic                           x_ack,
  output logic [XA_W-1:0]                xa,
  output logic [XD_W-1:0]                xd_out,
  output logic                           xd_oe,
  output logic                           x_we,
  output logic [NB-1:0]                  x_ms,
  output logic                           x_ioms,
  output logic [NPORT-1:0]               done
);
  typedef enum logic {ST_IDLE, ST_XFER} st_e;

  st_e               state_q;
  logic [PORT_W-1:0] owner_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              mode_q;
  logic [PORT_W-1:0] win;
  logic              any;
  logic [2:0]        widx;
  logic              fin;

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int p = NPORT - 1; p >= 0; p--)
      if (want[p]) begin
        win = PORT_W'(p);
        any = 1'b1;
      end
  end

  assign widx = (win == PORT_IO) ? 3'(NB) : {1'b0, p_bank[win]};
  assign fin  = (state_q == ST_XFER) && (cnt_q == '0) && (!mode_q || x_ack);

  always_comb begin
    done = '0;
    if (fin) done[owner_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      xa      <= '0;
      xd_out  <= '0;
      xd_oe   <= 1'b0;
      x_we    <= 1'b0;
      x_ms    <= '0;
      x_ioms  <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (any) begin
        state_q <= ST_XFER;
        owner_q <= win;
        cnt_q   <= wcount[widx];
        mode_q  <= wmode[widx];
        xa      <= p_xa[win];
        xd_out  <= p_wdata[win];
        xd_oe   <= p_we[win];
        x_we    <= p_we[win];
        if (win == PORT_IO) x_ioms <= 1'b1;
        else                x_ms   <= NB'(1) << p_bank[win];
      end
    end else if (fin) begin
      state_q <= ST_IDLE;
      xd_oe   <= 1'b0;
      x_we    <= 1'b0;
      x_ms    <= '0;
      x_ioms  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r9_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0({x_ms, x_ioms}));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> ({x_ms, x_ioms} == '0) && !xd_oe);
  a_r5_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER && !fin) |=> $stable(xa) && $stable(x_ms) && $stable(x_ioms));
  a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER && cnt_q != '0) |=> (state_q == ST_XFER) && (cnt_q == $past(cnt_q) - 1'b1));
  a_r7_ack_stretch: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER && cnt_q == '0 && mode_q && !x_ack) |=> (state_q == ST_XFER));
  a_r8_dm_first: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && want[PORT_DM]) |=> (owner_q == PORT_DM));
endmodule

// File: rtl/xbus_paged_ctrl.sv
module xbus_paged_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int PAGE_W        = 8,
  parameter int IO_W          = 18,
  parameter int XA_W          = 20,
  parameter int XD_W          = 16,
  parameter int WAIT_W        = 4,
  parameter int RAM0_WORDS    = 16384,
  parameter int RAM1_WORDS    = 16384,
  parameter int RAM2_WORDS    = 8192,
  parameter int ROM_WORDS     = 4096,
  parameter int IO_PAGE_SHIFT = 10,
  parameter int IO_INT_PAGES  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [XD_W-1:0]   cfg_wdata,
  input  logic              dm_req,
  input  logic [ADDR_W-1:0] dm_addr,
  input  logic              dm_we,
  input  logic [XD_W-1:0]   dm_wdata,
  output logic              dm_rdy,
  output logic [2:0]        dm_tgt,
  output logic [XD_W-1:0]   dm_rdata,
  input  logic              pm_req,
  input  logic [ADDR_W-1:0] pm_addr,
  input  logic              pm_we,
  input  logic [XD_W-1:0]   pm_wdata,
  output logic              pm_rdy,
  output logic [2:0]        pm_tgt,
  output logic [XD_W-1:0]   pm_rdata,
  input  logic              io_req,
  input  logic [IO_W-1:0]   io_addr,
  input  logic              io_we,
  input  logic [XD_W-1:0]   io_wdata,
  output logic              io_rdy,
  output logic [2:0]        io_tgt,
  output logic [XD_W-1:0]   io_rdata,
  output logic [XA_W-1:0]   xa,
  output logic [XD_W-1:0]   xd_out,
  output logic              xd_oe,
  input  logic [XD_W-1:0]   xd_in,
  output logic              x_we,
  input  logic              x_ack,
  output logic [NB-1:0]     x_ms,
  output logic              x_ioms
);
  localparam int NMEM = 2;

  logic [NB-2:0][PAGE_W-1:0] bnd;
  logic [NB:0][WAIT_W-1:0]   wcount;
  logic [NB:0]               wmode;

  logic [NMEM-1:0][ADDR_W-1:0] m_addr;
  tgt_e                        dec_tgt  [NPORT];
  logic [BANK_W-1:0]           dec_bank [NMEM];

  logic [NPORT-1:0]             req, we, is_ext, want, int_hit, ext_done;
  logic [NPORT-1:0][XA_W-1:0]   a_xa;
  logic [NPORT-1:0][XD_W-1:0]   a_wdata;
  logic [NPORT-1:0][BANK_W-1:0] a_bank;

  logic [NPORT-1:0]           rdy_q;
  logic [NPORT-1:0][2:0]      tgt_q;
  logic [NPORT-1:0][XD_W-1:0] rdata_q;

  xbus_cfg_regs #(.PAGE_W(PAGE_W), .WAIT_W(WAIT_W), .DW(XD_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bnd(bnd), .wcount(wcount), .wmode(wmode)
  );

  assign m_addr = {pm_addr, dm_addr};

  for (genvar g = 0; g < NMEM; g++) begin : g_mdec
    xbus_mem_decode #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .RAM0_WORDS(RAM0_WORDS),
      .RAM1_WORDS(RAM1_WORDS), .RAM2_WORDS(RAM2_WORDS), .ROM_WORDS(ROM_WORDS)
    ) u_dec (
      .addr(m_addr[g]), .bnd(bnd), .tgt(dec_tgt[g]), .bank(dec_bank[g])
    );
  end

  xbus_io_decode #(
    .IO_W(IO_W), .IO_PAGE_SHIFT(IO_PAGE_SHIFT), .IO_INT_PAGES(IO_INT_PAGES)
  ) u_iodec (
    .io_addr(io_addr), .tgt(dec_tgt[PORT_IO])
  );

  always_comb begin
    req = {io_req, pm_req, dm_req};
    we  = {io_we, pm_we, dm_we};
    a_wdata = {io_wdata, pm_wdata, dm_wdata};
    for (int p = 0; p < NMEM; p++) begin
      a_xa[p]   = m_addr[p][XA_W-1:0];
      a_bank[p] = dec_bank[p];
    end
    a_xa[PORT_IO]   = XA_W'(io_addr);
    a_bank[PORT_IO] = '0;
    for (int p = 0; p < NPORT; p++) begin
      is_ext[p]  = (dec_tgt[p] == TGT_EXT);
      want[p]    = req[p] && is_ext[p] && !rdy_q[p];
      int_hit[p] = req[p] && !is_ext[p] && !rdy_q[p];
    end
  end

  xbus_ext_arb #(.XA_W(XA_W), .XD_W(XD_W), .WAIT_W(WAIT_W)) u_arb (
    .clk(clk), .rst(rst), .want(want), .p_xa(a_xa), .p_we(we),
    .p_wdata(a_wdata), .p_bank(a_bank), .wcount(wcount), .wmode(wmode),
    .x_ack(x_ack), .xa(xa), .xd_out(xd_out), .xd_oe(xd_oe), .x_we(x_we),
    .x_ms(x_ms), .x_ioms(x_ioms), .done(ext_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q   <= '0;
      tgt_q   <= '0;
      rdata_q <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        rdy_q[p] <= int_hit[p] | ext_done[p];
        if (int_hit[p])       tgt_q[p] <= dec_tgt[p];
        else if (ext_done[p]) tgt_q[p] <= TGT_EXT;
        else                  tgt_q[p] <= TGT_NONE;
        rdata_q[p] <= (ext_done[p] && !we[p]) ? xd_in : '0;
      end
    end
  end

  assign dm_rdy   = rdy_q[PORT_DM];
  assign pm_rdy   = rdy_q[PORT_PM];
  assign io_rdy   = rdy_q[PORT_IO];
  assign dm_tgt   = tgt_q[PORT_DM];
  assign pm_tgt   = tgt_q[PORT_PM];
  assign io_tgt   = tgt_q[PORT_IO];
  assign dm_rdata = rdata_q[PORT_DM];
  assign pm_rdata = rdata_q[PORT_PM];
  assign io_rdata = rdata_q[PORT_IO];

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      rdy_q[g] |=> !rdy_q[g]);
    a_r12_rdata_only_on_rdy: assert property (@(posedge clk) disable iff (rst)
      !rdy_q[g] |-> (rdata_q[g] == '0));
  end
endmodule

// File: tb/xbus_paged_ctrl_bench.sv
module xbus_paged_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        b_req [3];
  logic [23:0] b_addr [3];
  logic        b_we [3];
  logic [15:0] b_wd [3];
  logic [15:0] xd_in = '0;
  logic        x_ack = 1'b1;

  logic dm_rdy, pm_rdy, io_rdy, xd_oe, x_we, x_ioms;
  logic [2:0] dm_tgt, pm_tgt, io_tgt;
  logic [15:0] dm_rdata, pm_rdata, io_rdata, xd_out;
  logic [19:0] xa;
  logic [3:0] x_ms;

  xbus_paged_ctrl u_xbus_paged_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dm_req(b_req[0]), .dm_addr(b_addr[0]), .dm_we(b_we[0]), .dm_wdata(b_wd[0]),
    .dm_rdy(dm_rdy), .dm_tgt(dm_tgt), .dm_rdata(dm_rdata),
    .pm_req(b_req[1]), .pm_addr(b_addr[1]), .pm_we(b_we[1]), .pm_wdata(b_wd[1]),
    .pm_rdy(pm_rdy), .pm_tgt(pm_tgt), .pm_rdata(pm_rdata),
    .io_req(b_req[2]), .io_addr(b_addr[2][17:0]), .io_we(b_we[2]), .io_wdata(b_wd[2]),
    .io_rdy(io_rdy), .io_tgt(io_tgt), .io_rdata(io_rdata),
    .xa(xa), .xd_out(xd_out), .xd_oe(xd_oe), .xd_in(xd_in), .x_we(x_we),
    .x_ack(x_ack), .x_ms(x_ms), .x_ioms(x_ioms)
  );

  int nchk = 0, nerr = 0, cyc = 0, wd = 0;
  bit finished = 0;
  int sel_cycles = 0, last_sel = 0, ack_low_left = 0;
  int rdy_tick [3], last_tgt [3];

  // behavioural reference state
  int m_bnd [3]; int m_wait [5]; int m_mode [5];
  int m_busy, m_owner, m_cnt, m_md, m_ms, m_ioms, m_xa, m_xd, m_wr;
  int m_rdy [3], m_tgt [3], m_rd [3];

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int dec_mem(int a, output int bank);
    int page = (a >> 16) & 255;
    int off = a & 'hFFFF;
    bank = (page < m_bnd[0]) ? 0 : (page < m_bnd[1]) ? 1 : (page < m_bnd[2]) ? 2 : 3;
    if (page == 0) return (off < 'h4000) ? 1 : (off < 'h8000) ? 2 : (off < 'hA000) ? 3 : 6;
    if (page == 255 && off >= 'hF000) return 4;
    return 5;
  endfunction

  function automatic void model_reset();
    m_bnd[0] = 'h40; m_bnd[1] = 'h80; m_bnd[2] = 'hC0;
    for (int i = 0; i < 5; i++) begin m_wait[i] = 0; m_mode[i] = 0; end
    m_busy = 0; m_owner = 0; m_cnt = 0; m_md = 0; m_ms = 0; m_ioms = 0;
    m_xa = 0; m_xd = 0; m_wr = 0;
    for (int p = 0; p < 3; p++) begin m_rdy[p] = 0; m_tgt[p] = 0; m_rd[p] = 0; end
  endfunction

  function automatic void model_step();
    int tg [3]; int bk [3]; int nr [3]; int nt [3]; int nd [3];
    int fin_p = -1; int win = -1;
    for (int p = 0; p < 3; p++) begin
      bk[p] = 0;
      if (p < 2) tg[p] = dec_mem(int'(b_addr[p]), bk[p]);
      else tg[p] = ((int'(b_addr[2][17:0]) >> 10) < 32) ? 7 : 5;
    end
    if (m_busy != 0 && m_cnt == 0 && (m_md == 0 || x_ack)) fin_p = m_owner;
    for (int p = 0; p < 3; p++) begin
      nr[p] = 0; nt[p] = 0; nd[p] = 0;
      if (b_req[p] && tg[p] != 5 && m_rdy[p] == 0) begin nr[p] = 1; nt[p] = tg[p]; end
      else if (fin_p == p) begin nr[p] = 1; nt[p] = 5; nd[p] = b_we[p] ? 0 : int'(xd_in); end
      if (win < 0 && b_req[p] && tg[p] == 5 && m_rdy[p] == 0) win = p;
    end
    if (m_busy == 0) begin
      if (win >= 0) begin
        int idx = (win == 2) ? 4 : bk[win];
        m_busy = 1; m_owner = win; m_cnt = m_wait[idx]; m_md = m_mode[idx];
        m_xa = (win == 2) ? int'(b_addr[2][17:0]) : (int'(b_addr[win]) & 'hFFFFF);
        m_xd = int'(b_wd[win]); m_wr = b_we[win] ? 1 : 0;
        m_ms = (win == 2) ? 0 : (1 << bk[win]); m_ioms = (win == 2) ? 1 : 0;
      end
    end else if (fin_p >= 0) begin
      m_busy = 0; m_ms = 0; m_ioms = 0; m_wr = 0;
    end else if (m_cnt > 0) m_cnt--;
    for (int p = 0; p < 3; p++) begin m_rdy[p] = nr[p]; m_tgt[p] = nt[p]; m_rd[p] = nd[p]; end
    if (cfg_we) begin
      if (cfg_addr < 3) m_bnd[cfg_addr] = int'(cfg_wdata[7:0]);
      else begin
        int idx = (cfg_addr == 3) ? 4 : int'(cfg_addr) - 4;
        m_wait[idx] = int'(cfg_wdata[3:0]); m_mode[idx] = cfg_wdata[15] ? 1 : 0;
      end
    end
  endfunction

  task automatic compare();
    logic [2:0] r; logic [2:0] t [3]; logic [15:0] d [3];
    r = {io_rdy, pm_rdy, dm_rdy};
    t[0] = dm_tgt; t[1] = pm_tgt; t[2] = io_tgt;
    d[0] = dm_rdata; d[1] = pm_rdata; d[2] = io_rdata;
    chk("R3", "x_ms", int'(x_ms), m_ms);
    chk("R4", "x_ioms", int'(x_ioms), m_ioms);
    chk("R9", "select count", $countones({x_ms, x_ioms}) <= 1, 1);
    chk("R5", "xa", int'(xa), m_xa);
    chk("R5", "xd_out", int'(xd_out), m_xd & 'hFFFF);
    chk("R5", "x_we", int'(x_we), m_wr);
    chk("R5", "xd_oe", int'(xd_oe), m_wr);
    for (int p = 0; p < 3; p++) begin
      chk("R6", $sformatf("rdy[%0d]", p), int'(r[p]), m_rdy[p]);
      chk("R1", $sformatf("tgt[%0d]", p), int'(t[p]), m_tgt[p]);
      chk("R12", $sformatf("rdata[%0d]", p), int'(d[p]), m_rd[p]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    cyc++;
    if (!rst) compare();
    if ({x_ms, x_ioms} != 0) begin sel_cycles++; last_sel = int'({x_ioms, x_ms}); end
    if (dm_rdy) begin rdy_tick[0] = cyc; last_tgt[0] = int'(dm_tgt); end
    if (pm_rdy) begin rdy_tick[1] = cyc; last_tgt[1] = int'(pm_tgt); end
    if (io_rdy) begin rdy_tick[2] = cyc; last_tgt[2] = int'(io_tgt); end
    xd_in = 16'((cyc * 37) ^ 'hA5C3);
    if (ack_low_left > 0) ack_low_left--;
    x_ack = (ack_low_left == 0);
  endtask

  task automatic issue(int p, int a, bit w, int d);
    b_req[p] = 1'b1; b_addr[p] = 24'(a); b_we[p] = w; b_wd[p] = 16'(d);
  endtask

  task automatic run();
    for (int n = 0; n < 300; n++) begin
      if (!b_req[0] && !b_req[1] && !b_req[2]) return;
      tick();
      if (dm_rdy) b_req[0] = 1'b0;
      if (pm_rdy) b_req[1] = 1'b0;
      if (io_rdy) b_req[2] = 1'b0;
    end
    chk("R6", "request completion timeout", 0, 1);
    for (int p = 0; p < 3; p++) b_req[p] = 1'b0;
  endtask

  task automatic cfg_write(int a, int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic one(int p, int a, bit w, int d);
    sel_cycles = 0; last_sel = 0;
    issue(p, a, w, d);
    run();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && !finished) begin
      finished = 1;
      nerr++; nchk++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      b_req[p] = 0; b_addr[p] = '0; b_we[p] = 0; b_wd[p] = '0; rdy_tick[p] = 0; last_tgt[p] = 0;
    end
    model_reset();
    repeat (4) tick();
    rst = 1'b0;
    // R11: reset state visible at the ports
    chk("R11", "selects after reset", int'({x_ms, x_ioms}), 0);
    chk("R11", "ready after reset", int'({dm_rdy, pm_rdy, io_rdy}), 0);
    chk("R11", "bus drive after reset", int'({xd_oe, x_we}), 0);
    tick();

    // R1: page-0 RAM blocks and the hole above them
    one(1, 'h000000, 0, 0); chk("R1", "ram0 code", last_tgt[1], 1);
    one(1, 'h005000, 0, 0); chk("R1", "ram1 code", last_tgt[1], 2);
    one(0, 'h009FFF, 1, 'h1234); chk("R1", "ram2 top code", last_tgt[0], 3);
    one(0, 'h00A000, 0, 0); chk("R1", "page0 hole error", last_tgt[0], 6);
    one(0, 'h003FFF, 0, 0); chk("R1", "ram0 top code", last_tgt[0], 1);

    // R2: boot ROM at the top of the last page
    one(1, 'hFFF000, 0, 0); chk("R2", "rom base", last_tgt[1], 4);
    one(1, 'hFFFFFF, 0, 0); chk("R2", "rom top", last_tgt[1], 4);
    one(1, 'hFFEFFF, 0, 0); chk("R2", "below rom external", last_tgt[1], 5);
    chk("R3", "below rom in bank3", last_sel, 8);

    // R3: default bank boundaries
    one(0, 'h010000, 0, 0); chk("R3", "page 1 bank0", last_sel, 1);
    one(0, 'h7F1234, 1, 'hBEEF); chk("R3", "page 7F bank1", last_sel, 2);
    one(0, 'h800000, 0, 0); chk("R3", "page 80 bank2", last_sel, 4);
    one(1, 'hC00000, 0, 0); chk("R3", "page C0 bank3", last_sel, 8);

    // R6: wait count 3 on bank0 holds the strobe four cycles
    cfg_write(4, 3);
    one(0, 'h012345, 1, 'h55AA); chk("R6", "strobe cycles wait 3", sel_cycles, 4);
    one(1, 'h012346, 0, 0); chk("R12", "read completes", last_tgt[1], 5);

    // R7: acknowledge mode on bank1, wait 1, ack low for five ticks
    cfg_write(5, 'h8001);
    sel_cycles = 0;
    ack_low_left = 5; x_ack = 1'b0;
    issue(0, 'h410000, 0, 0);
    run();
    chk("R7", "strobe cycles with ack stretch", sel_cycles, 5);

    // R4: I/O space on-chip and external pages
    cfg_write(3, 2);
    one(2, 'h00123, 0, 0); chk("R4", "io page 0 on-chip", last_tgt[2], 7);
    one(2, 'h07FFF, 0, 0); chk("R4", "io page 31 on-chip", last_tgt[2], 7);
    one(2, 'h08000, 1, 'h0F0F); chk("R4", "io page 32 external", last_tgt[2], 5);
    chk("R4", "io select used", last_sel, 16);
    chk("R6", "io strobe cycles wait 2", sel_cycles, 3);

    // R8: three simultaneous external requests
    cfg_write(4, 1);
    issue(1, 'h020000, 0, 0);
    issue(0, 'h030000, 1, 'h7777);
    issue(2, 'h3FFFF, 0, 0);
    run();
    chk("R8", "dm before pm", int'(rdy_tick[0] < rdy_tick[1]), 1);
    chk("R8", "pm before io", int'(rdy_tick[1] < rdy_tick[2]), 1);

    // R10: a wait-count write during a transfer affects only later ones
    cfg_write(6, 2);
    sel_cycles = 0;
    issue(0, 'h900000, 1, 'h2222);
    tick();
    cfg_write(6, 7);
    run();
    chk("R10", "in-flight transfer keeps old wait", sel_cycles, 3);
    one(0, 'h900001, 0, 0); chk("R10", "next transfer uses new wait", sel_cycles, 8);

    // R10: reprogrammed boundaries
    cfg_write(0, 'h10); cfg_write(1, 'h20); cfg_write(2, 'h30);
    one(0, 'h050000, 0, 0); chk("R10", "page 05 bank0", last_sel, 1);
    one(0, 'h150000, 0, 0); chk("R10", "page 15 bank1", last_sel, 2);
    one(1, 'h250000, 0, 0); chk("R10", "page 25 bank2", last_sel, 4);
    one(1, 'h350000, 0, 0); chk("R10", "page 35 bank3", last_sel, 8);
    repeat (3) tick();
    chk("R9", "idle bus no select", int'({x_ms, x_ioms}), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule